// File: doc/BRIEF.md
# Lazy FPU Context Trap Controller

This block gates floating-point instruction issue behind a single task-switched flag. Every task-switch event raises the flag without any software action. While the flag is raised, any floating-point instruction that reaches decode is refused and turned into a restartable fault on vector 7. The fault carries that instruction's own address as the return point. The operating system's handler can then save the previous owner's floating-point state and load the current task's state. After that it clears the flag with a privileged command and returns, so the same instruction issues on the retry.

When the flag is low, floating-point instructions issue in their decode cycle with no added latency. A clear command from any privilege level other than 0 leaves the flag untouched and raises a protection-fault request. The flag is also visible as bit 3 of a control-word output, so software that reads the control register sees it there. The floating-point datapath, the state save and restore, and exception dispatch are all outside this block.

Top module: `lazy_fpu_trap`

## Requirements
- R1: After reset the flag is 0. `ctl_word_o` is all zeros, and `issue_o`, `fault_o` and `prot_fault_o` are low.
- R2: A cycle with `task_switch_i` high makes the flag 1 from the next cycle on.
- R3: A cycle with `clr_flag_i` high, `cpl_i` equal to 0 and no task switch makes the flag 0 from the next cycle on.
- R4: A floating-point decode (`fp_valid_i` high) while the flag is 1 raises `fault_o` and keeps `issue_o` low in that same cycle, with `fault_vec_o` equal to 7. At every other time `fault_vec_o` is 0.
- R5: In a fault cycle, `fault_addr_o` equals `fp_addr_i`, which is the address of the faulting instruction, so the instruction is retried on return.
- R6: A floating-point decode while the flag is 0 raises `issue_o` in that same cycle and raises no fault.
- R7: A clear command with a nonzero `cpl_i` leaves the flag unchanged and raises `prot_fault_o` in that cycle.
- R8: When a task switch and a privileged clear arrive in the same cycle, the flag ends at 1.
- R9: Bit 3 of `ctl_word_o` carries the flag, and all other bits read 0.
- R10: The issue and trap decision uses the flag value held at the start of the cycle. A set or clear in the decode cycle only affects later instructions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| task_switch_i | input | 1 | Task-switch event pulse |
| clr_flag_i | input | 1 | Clear-flag command |
| cpl_i | input | PL_W | Current privilege level of the command |
| fp_valid_i | input | 1 | Floating-point instruction at decode |
| fp_addr_i | input | ADDR_W | Address of the decoded instruction |
| issue_o | output | 1 | Issue grant |
| fault_o | output | 1 | Trap request |
| fault_vec_o | output | 8 | Trap vector, 7 when `fault_o` is high |
| fault_addr_o | output | ADDR_W | Return address for the trap |
| prot_fault_o | output | 1 | Protection-fault request for an unprivileged clear |
| ctl_word_o | output | CW_W | Control-word view with the flag at bit 3 |

## Verification
A vector sequence steps the flag through set, trapped decode, rejected clear, privileged clear and retried issue. Checking both the grant and the trap on every step separates the issue path from the trap path. The sequence also contains same-cycle collisions: a switch with a clear, a decode with a clear, and a decode with a switch. These show whether the set has priority and whether decisions use the flag as held at the start of the cycle rather than its next value. Directed steps cover the reset state and a reset that arrives while the flag is set.

// File: rtl/lazy_fpu_trap.sv
module lazy_fpu_trap #(
  parameter int ADDR_W = 32,
  parameter int PL_W   = 2,
  parameter int CW_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              task_switch_i,
  input  logic              clr_flag_i,
  input  logic [PL_W-1:0]   cpl_i,
  input  logic              fp_valid_i,
  input  logic [ADDR_W-1:0] fp_addr_i,
  output logic              issue_o,
  output logic              fault_o,
  output logic [7:0]        fault_vec_o,
  output logic [ADDR_W-1:0] fault_addr_o,
  output logic              prot_fault_o,
  output logic [CW_W-1:0]   ctl_word_o
);
  localparam int         FLAG_POS = 3;
  localparam logic [7:0] TRAP_VEC = 8'd7;

  logic ts_q;
  logic priv_clr;

  assign priv_clr     = clr_flag_i && (cpl_i == '0);
  assign prot_fault_o = clr_flag_i && (cpl_i != '0);

  always_ff @(posedge clk) begin
    if (!rst_n)             ts_q <= 1'b0;
    else if (task_switch_i) ts_q <= 1'b1;
    else if (priv_clr)      ts_q <= 1'b0;
  end

  assign issue_o      = fp_valid_i && !ts_q;
  assign fault_o      = fp_valid_i && ts_q;
  assign fault_vec_o  = fault_o ? TRAP_VEC : 8'd0;
  assign fault_addr_o = fault_o ? fp_addr_i : '0;

  always_comb begin
    ctl_word_o           = '0;
    ctl_word_o[FLAG_POS] = ts_q;
  end
endmodule

module lazy_fpu_trap_chk #(
  parameter int ADDR_W = 32,
  parameter int PL_W   = 2,
  parameter int CW_W   = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              task_switch_i,
  input logic              clr_flag_i,
  input logic [PL_W-1:0]   cpl_i,
  input logic              fp_valid_i,
  input logic [ADDR_W-1:0] fp_addr_i,
  input logic              issue_o,
  input logic              fault_o,
  input logic [7:0]        fault_vec_o,
  input logic [ADDR_W-1:0] fault_addr_o,
  input logic              prot_fault_o,
  input logic [CW_W-1:0]   ctl_word_o
);
  // R2
  ts_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    task_switch_i |=> ctl_word_o[3]);
  // R3
  clr_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_flag_i && cpl_i == '0 && !task_switch_i) |=> !ctl_word_o[3]);
  // R7
  unpriv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_flag_i && cpl_i != '0 && !task_switch_i) |=> (ctl_word_o[3] == $past(ctl_word_o[3])));
  // R4
  trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fp_valid_i && ctl_word_o[3]) |-> (fault_o && !issue_o && fault_vec_o == 8'd7));
  // R5
  ret_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> (fault_addr_o == fp_addr_i));
  // R6
  grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fp_valid_i && !ctl_word_o[3]) |-> (issue_o && !fault_o));
  // R4
  excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({issue_o, fault_o}));
  // R9
  only_bit3_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ctl_word_o) <= 1 && (ctl_word_o & ~(CW_W'(1) << 3)) == '0);
  // R2
  rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_word_o[3]) |-> $past(task_switch_i));
endmodule

bind lazy_fpu_trap lazy_fpu_trap_chk #(.ADDR_W(ADDR_W), .PL_W(PL_W), .CW_W(CW_W)) chk_i (.*);

// File: tb/lazy_fpu_trap_tb.sv
module lazy_fpu_trap_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int NV = 11;

  // {ts, clr, cpl[1:0], fp, exp_issue, exp_fault, exp_prot, exp_flag_next}
  localparam logic [8:0] VEC [NV] = '{
    9'b0_0_00_1_1_0_0_0,  // R6 grant with flag clear
    9'b1_0_00_0_0_0_0_1,  // R2 switch sets flag
    9'b0_0_00_1_0_1_0_1,  // R4 trap
    9'b0_1_11_0_0_0_1_1,  // R7 unprivileged clear rejected
    9'b0_0_00_1_0_1_0_1,  // R4 still trapping
    9'b0_1_00_0_0_0_0_0,  // R3 privileged clear
    9'b0_0_00_1_1_0_0_0,  // R6 retry issues
    9'b1_1_00_0_0_0_0_1,  // R8 switch beats clear
    9'b0_1_00_1_0_1_0_0,  // R10 decode sees old flag 1
    9'b1_0_00_1_1_0_0_1,  // R10 decode sees old flag 0
    9'b0_1_01_0_0_0_1_1   // R7 level 1 rejected
  };

  logic clk = 0, rst_n = 0;
  logic ts = 0, clr = 0, fp = 0;
  logic [1:0] cpl = 0;
  logic [AW-1:0] addr = 0;
  logic issue, fault, prot;
  logic [7:0] vec;
  logic [AW-1:0] faddr;
  logic [31:0] cw;
  int errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lazy_fpu_trap dut_i (
    .clk(clk), .rst_n(rst_n), .task_switch_i(ts), .clr_flag_i(clr), .cpl_i(cpl),
    .fp_valid_i(fp), .fp_addr_i(addr), .issue_o(issue), .fault_o(fault),
    .fault_vec_o(vec), .fault_addr_o(faddr), .prot_fault_o(prot), .ctl_word_o(cw)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD*5000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    #1;
    check(cw == 0, "R1 flag", cw, 0);
    check(!issue && !fault && !prot, "R1 outputs", {issue, fault, prot}, 0);
    @(negedge clk) rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      logic [8:0] v;
      v = VEC[i];
      @(negedge clk);
      {ts, clr, cpl, fp} = v[8:4];
      addr = 32'h1000 + 32'(i) * 4;
      #(CLK_PERIOD/4);
      check(issue == v[3], $sformatf("R6/R10 issue step %0d", i), issue, v[3]);
      check(fault == v[2], $sformatf("R4/R10 fault step %0d", i), fault, v[2]);
      check(prot == v[1], $sformatf("R7 prot step %0d", i), prot, v[1]);
      if (v[2]) begin
        check(vec == 8'd7, "R4 vector", vec, 7);
        check(faddr == addr, "R5 return address", faddr, addr);
      end else
        check(vec == 8'd0, "R4 vector idle", vec, 0);
      @(posedge clk);
      #1;
      check(cw == (32'(v[0]) << 3), $sformatf("R2/R3/R8/R9 flag step %0d", i), cw, 32'(v[0]) << 3);
      {ts, clr, cpl, fp} = 0;
    end

    // R1 reset while flag is set
    @(negedge clk) rst_n = 0;
    @(posedge clk); #1;
    check(cw == 0, "R1 reset clears flag", cw, 0);
    @(negedge clk) rst_n = 1; fp = 1; addr = 32'hABC0;
    #1;
    check(issue && !fault, "R1 R6 issue after reset", {issue, fault}, 2);
    @(negedge clk) fp = 0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule